// File: doc/BRIEF.md
# Line-Count Lock Status Filter

This block turns the raw, line-by-line lock indications from a video sync processor into a steady locked or unlocked status. Each horizontal line is marked by a one-cycle line strobe. On every strobe the block looks at one of two raw lock inputs, chosen by a select pin. It changes the reported status only after the raw value has disagreed with that status on enough consecutive lines. The entry and exit thresholds come from two separate 3-bit codes, so the status has hysteresis.

Three further outputs support the system around the block. A sticky flag remembers that lock was lost at some point and stays set until a read-clear strobe. Two single-cycle pulses mark each gained and each lost lock for an interrupt controller. Every pin is a plain control or status pin. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `lock_qual_top`

## Requirements
- R1: After reset the status is unlocked (0), the sticky flag is 0 and both event pulses are 0.
- R2: When `src_sel` is 0 the raw lock value is `raw_lock_a`, and when it is 1 the raw lock value is `raw_lock_b`. The input that is not selected has no effect.
- R3: While the status is unlocked, it becomes locked after the raw value has been 1 on N consecutive strobed lines. N is set by `enter_code`: 0→1, 1→2, 2→5, 3→10, 4→100, 5→500, 6→1000, 7→100000.
- R4: While the status is locked, it becomes unlocked after the raw value has been 0 on N consecutive strobed lines. N is set by `exit_code`, using the same mapping as R3.
- R5: A strobed line whose raw value equals the current status discards any partial count, so the next disagreeing line starts again from one.
- R6: Raw and select values are used only in cycles where `line_stb` is 1. In all other cycles the status and the counts do not change.
- R7: The status updates in the cycle after the clock edge that samples the deciding line. In that same cycle `lock_gained` (for a rise) or `lock_lost` (for a fall) is 1 for exactly one cycle.
- R8: `lost_sticky` becomes 1 together with `lock_lost` and stays 1 until a cycle with `rd_clr` = 1 clears it. If a loss and `rd_clr` fall in the same cycle, the flag stays set.
- R9: The count code is taken when the first disagreeing line arrives. Changes to `enter_code` or `exit_code` while a count is in progress do not alter that count's threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb | input | 1 | One strobe per video line |
| raw_lock_a | input | 1 | Raw lock candidate 0 |
| raw_lock_b | input | 1 | Raw lock candidate 1 |
| src_sel | input | 1 | Raw source select |
| enter_code | input | 3 | Lines-to-lock code |
| exit_code | input | 3 | Lines-to-unlock code |
| rd_clr | input | 1 | Read-clear for the sticky flag |
| lock_status | output | 1 | Filtered lock status |
| lost_sticky | output | 1 | Lock lost since last clear |
| lock_gained | output | 1 | One-cycle pulse on lock entry |
| lock_lost | output | 1 | One-cycle pulse on lock exit |

## Verification
A table of line sequences drives both raw sources and switches the select in the middle. This separates a filter that follows the chosen input from one that follows the wrong input. Runs of exactly N−1 and N agreeing lines show whether a threshold is off by one. Runs broken by a single agreeing line show whether the partial count really restarts. Directed runs cover the long codes, a code change during a count, raw toggles between strobes, and a read-clear that lands in the same cycle as a loss.

// File: rtl/lock_qual_pkg.sv
package lock_qual_pkg;
  localparam int MAX_LINES = 100000;

  // Converts a 3-bit count code into a line count.
  function automatic int code_lines(input logic [2:0] code);
    case (code)
      3'd0: code_lines = 1;
      3'd1: code_lines = 2;
      3'd2: code_lines = 5;
      3'd3: code_lines = 10;
      3'd4: code_lines = 100;
      3'd5: code_lines = 500;
      3'd6: code_lines = 1000;
      default: code_lines = MAX_LINES;
    endcase
  endfunction
endpackage

// File: rtl/lock_src_mux.sv
module lock_src_mux #(
  parameter int NSRC = 2,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] raw_i,
  input  logic [SW-1:0]   sel_i,
  output logic            raw_o
);
  logic [NSRC-1:0] pick;
  for (genvar g = 0; g < NSRC; g++) begin : g_pick
    assign pick[g] = raw_i[g] & (sel_i == SW'(g));
  end
  assign raw_o = |pick;
endmodule

// File: rtl/lock_hyst_counter.sv
module lock_hyst_counter
  import lock_qual_pkg::*;
#(
  parameter int LINES_MAX = MAX_LINES,
  localparam int CW = $clog2(LINES_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb_i,
  input  logic       raw_i,
  input  logic [2:0] enter_code_i,
  input  logic [2:0] exit_code_i,
  output logic       status_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic          status_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tgt_q;
  logic [CW-1:0] thresh;
  logic [CW-1:0] cnt_inc;
  logic          disagree;
  logic          flip;

  // The code is taken from the pin only when no count is in progress.
  assign thresh   = (cnt_q == '0) ? CW'(code_lines(status_q ? exit_code_i : enter_code_i)) : tgt_q;
  assign cnt_inc  = cnt_q + CW'(1);
  assign disagree = line_stb_i && (raw_i != status_q);
  assign flip     = disagree && (cnt_inc >= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      cnt_q    <= '0;
      tgt_q    <= '0;
    end else if (line_stb_i) begin
      if (!disagree) begin
        cnt_q <= '0;
      end else if (flip) begin
        status_q <= ~status_q;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_inc;
        if (cnt_q == '0) tgt_q <= thresh;
      end
    end
  end

  assign status_o = status_q;
  assign rise_o   = flip && !status_q;
  assign fall_o   = flip && status_q;

  assert_status_on_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_stb_i) |-> $stable(status_q));
  assert_count_below_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < tgt_q));
  assert_target_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) != '0 && cnt_q != '0) |-> $stable(tgt_q));
endmodule

// File: rtl/lock_event_flags.sv
module lock_event_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic fall_i,
  input  logic rd_clr_i,
  input  logic status_i,
  output logic gained_o,
  output logic lost_o,
  output logic sticky_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gained_o <= 1'b0;
      lost_o   <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      gained_o <= rise_i;
      lost_o   <= fall_i;
      // A new loss takes precedence over a clear in the same cycle.
      sticky_o <= fall_i | (sticky_o & ~rd_clr_i);
    end
  end

  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gained_o && lost_o));
  assert_gain_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_i) |-> gained_o);
  assert_loss_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_i) |-> lost_o);
  assert_sticky_with_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> sticky_o);
endmodule

// File: rtl/lock_qual_top.sv
module lock_qual_top
  import lock_qual_pkg::*;
#(
  parameter int LINES_MAX = MAX_LINES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb,
  input  logic       raw_lock_a,
  input  logic       raw_lock_b,
  input  logic       src_sel,
  input  logic [2:0] enter_code,
  input  logic [2:0] exit_code,
  input  logic       rd_clr,
  output logic       lock_status,
  output logic       lost_sticky,
  output logic       lock_gained,
  output logic       lock_lost
);
  logic raw_sel;
  logic rise;
  logic fall;

  lock_src_mux #(.NSRC(2)) u_mux (
    .raw_i ({raw_lock_b, raw_lock_a}),
    .sel_i (src_sel),
    .raw_o (raw_sel)
  );

  lock_hyst_counter #(.LINES_MAX(LINES_MAX)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_stb_i   (line_stb),
    .raw_i        (raw_sel),
    .enter_code_i (enter_code),
    .exit_code_i  (exit_code),
    .status_o     (lock_status),
    .rise_o       (rise),
    .fall_o       (fall)
  );

  lock_event_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise),
    .fall_i   (fall),
    .rd_clr_i (rd_clr),
    .status_i (lock_status),
    .gained_o (lock_gained),
    .lost_o   (lock_lost),
    .sticky_o (lost_sticky)
  );

  assert_reset_unlocked_R1: assert property (@(posedge clk)
    !rst_n |=> (!lock_status || rst_n));
endmodule

// File: tb/tb_lock_qual_top.sv
`timescale 1ns/1ps
module tb_lock_qual_top;
  logic clk = 0, rst_n = 0, line_stb = 0, raw_lock_a = 0, raw_lock_b = 0;
  logic src_sel = 0, rd_clr = 0;
  logic [2:0] enter_code = 0, exit_code = 0;
  logic lock_status, lost_sticky, lock_gained, lock_lost;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  lock_qual_top dut (.*);

  // {sel, a, b, enter, exit, nlines[7:0], expected status}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,3'd1,3'd0,8'd1,1'b0},  // R3 1 of 2
    {1'b0,1'b1,1'b0,3'd1,3'd0,8'd1,1'b1},  // R3 2 of 2
    {1'b1,1'b1,1'b0,3'd1,3'd0,8'd1,1'b0},  // R2 b selected, R4 exit 1
    {1'b1,1'b0,1'b1,3'd2,3'd0,8'd4,1'b0},  // R3 4 of 5
    {1'b1,1'b0,1'b1,3'd2,3'd0,8'd1,1'b1},  // R3 5 of 5
    {1'b0,1'b0,1'b1,3'd2,3'd3,8'd9,1'b1},  // R4 9 of 10
    {1'b0,1'b0,1'b1,3'd2,3'd3,8'd1,1'b0},  // R4 10 of 10
    {1'b0,1'b1,1'b0,3'd0,3'd3,8'd1,1'b1},  // R3 code 0
    {1'b0,1'b0,1'b0,3'd3,3'd0,8'd1,1'b0},  // R4 code 0
    {1'b0,1'b1,1'b0,3'd3,3'd0,8'd9,1'b0},  // R5 9 of 10
    {1'b0,1'b0,1'b0,3'd3,3'd0,8'd1,1'b0},  // R5 break
    {1'b0,1'b1,1'b0,3'd3,3'd0,8'd9,1'b0},  // R5 restart, 9
    {1'b0,1'b1,1'b0,3'd3,3'd0,8'd1,1'b1}   // R5 10th
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Strobe n consecutive lines with raw_lock_a = a, then idle one cycle.
  task automatic lines(input int n, input logic a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); raw_lock_a = a; line_stb = 1;
    end
    @(negedge clk); line_stb = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; line_stb = 0; rd_clr = 0; src_sel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; @(negedge clk);
  endtask

  initial begin
    do_reset();
    check(lock_status, 1'b0, "R1 status");
    check(lost_sticky, 1'b0, "R1 sticky");
    check(lock_gained | lock_lost, 1'b0, "R1 pulses");

    for (int v = 0; v < NV; v++) begin
      {src_sel, raw_lock_a, raw_lock_b, enter_code, exit_code} = VEC[v][17:9];
      for (int i = 0; i < int'(VEC[v][8:1]); i++) begin
        @(negedge clk); line_stb = 1;
      end
      @(negedge clk); line_stb = 0;
      check(lock_status, VEC[v][0], $sformatf("R3/R4/R5 vector %0d", v));
    end

    // R6: toggling raw without strobes changes nothing (status locked here).
    exit_code = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); raw_lock_a = i[0]; raw_lock_b = ~i[0]; src_sel = i[1];
    end
    @(negedge clk); src_sel = 0;
    check(lock_status, 1'b1, "R6 no strobe");

    // R7/R8: loss with simultaneous clear, pulse width, later clear.
    @(negedge clk); raw_lock_a = 0; line_stb = 1; rd_clr = 1;
    @(negedge clk); line_stb = 0; rd_clr = 0;
    check(lock_status, 1'b0, "R7 status fell");
    check(lock_lost, 1'b1, "R7 loss pulse");
    check(lost_sticky, 1'b1, "R8 loss beats clear");
    @(negedge clk);
    check(lock_lost, 1'b0, "R7 loss pulse one cycle");
    check(lost_sticky, 1'b1, "R8 sticky holds");
    rd_clr = 1; @(negedge clk); rd_clr = 0;
    check(lost_sticky, 1'b0, "R8 cleared");

    // R7 gain pulse.
    enter_code = 0;
    @(negedge clk); raw_lock_a = 1; line_stb = 1;
    @(negedge clk); line_stb = 0;
    check(lock_gained, 1'b1, "R7 gain pulse");
    @(negedge clk);
    check(lock_gained, 1'b0, "R7 gain pulse one cycle");

    // R9: code change mid count does not shorten it.
    do_reset();
    enter_code = 3; lines(3, 1'b1);
    enter_code = 0; lines(6, 1'b1);
    check(lock_status, 1'b0, "R9 9 of 10 after code change");
    lines(1, 1'b1);
    check(lock_status, 1'b1, "R9 10th line");

    // R4 exit codes 4 and 5 (100, 500).
    exit_code = 4; lines(99, 1'b0);
    check(lock_status, 1'b1, "R4 99 of 100");
    lines(1, 1'b0);
    check(lock_status, 1'b0, "R4 100 of 100");
    enter_code = 0; lines(1, 1'b1);
    exit_code = 5; lines(499, 1'b0);
    check(lock_status, 1'b1, "R4 499 of 500");
    lines(1, 1'b0);
    check(lock_status, 1'b0, "R4 500 of 500");

    // R3 entry codes 6 and 7 (1000, 100000).
    enter_code = 6; lines(999, 1'b1);
    check(lock_status, 1'b0, "R3 999 of 1000");
    lines(1, 1'b1);
    check(lock_status, 1'b1, "R3 1000 of 1000");
    exit_code = 0; lines(1, 1'b0);
    enter_code = 7; lines(99999, 1'b1);
    check(lock_status, 1'b0, "R3 99999 of 100000");
    lines(1, 1'b1);
    check(lock_status, 1'b1, "R3 100000 of 100000");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule